// File: doc/BRIEF.md
# Wrap-Bit Ring Pointer Tracker

This block keeps the two pointers of a byte-addressed circular buffer shared between a peripheral data mover and software. It computes how full the buffer is from those pointers and a programmed length. Each pointer is an offset field with one extra flag bit above it. The flag flips every time the pointer passes the end of the buffer, so a full buffer and an empty buffer can be told apart even though their offsets are equal.

A direction input picks the hardware side. In receive mode, hardware fills the buffer by advancing the write pointer, and software consumes data by writing the read pointer. In transmit mode, software fills the buffer by writing the write pointer, and hardware drains it by advancing the read pointer.

From the pointer registers the block derives two sizes:
- occupancy (valid size);
- free space (left size).

It also raises two level requests by comparing those sizes with a programmed threshold. Memory access itself happens elsewhere.

Top module: `ring_ptr_tracker`

## Requirements
- R1: After reset both pointers are zero, including their wrap flags (bit 16), valid size is zero and left size equals the programmed length.
- R2: A one-cycle hardware advance pulse moves the write pointer when the direction input is 1 (receive), and the read pointer when it is 0 (transmit), by one byte.
- R3: A pointer uses offset in bits 15:0 and wrap flag in bit 16. When an advance makes the offset equal the programmed length, the offset becomes zero and the wrap flag inverts.
- R4: Valid size is the write offset minus the read offset. The programmed length is added when the two wrap flags differ.
- R5: Left size equals the programmed length minus valid size, so the two always sum to the length.
- R6: The receive request is high when valid size is at least the threshold. The transmit request is high when left size is at least the threshold.
- R7: A hardware advance has no effect on the write pointer when the buffer is full (receive). It has no effect on the read pointer when the buffer is empty (transmit).
- R8: A software write loads the selected pointer with the 17-bit value on the next edge. Writing the read pointer with the write pointer's value empties the buffer.
- R9: When software writes the same pointer that a hardware advance targets in the same cycle, the software value is taken.
- R10: While the programmed length is zero, both pointers are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rx_i | input | 1 | 1: hardware advances write pointer; 0: hardware advances read pointer |
| hw_adv_i | input | 1 | One-byte hardware advance pulse |
| sw_rd_we_i | input | 1 | Software write strobe for the read pointer |
| sw_wr_we_i | input | 1 | Software write strobe for the write pointer |
| sw_ptr_i | input | 17 | Pointer value for software writes (wrap flag in bit 16) |
| len_i | input | 16 | Programmed buffer length in bytes |
| thr_i | input | 16 | Request threshold |
| rd_ptr_o | output | 17 | Read pointer |
| wr_ptr_o | output | 17 | Write pointer |
| valid_o | output | 16 | Valid size (occupancy) |
| left_o | output | 16 | Left size (free space) |
| rx_req_o | output | 1 | Receive threshold request |
| tx_req_o | output | 1 | Transmit threshold request |

## Verification
A software pointer write and a hardware advance can land on the same clock edge. Either they target the same pointer, where software must win, or they target opposite pointers, where both must take effect against the pre-edge occupancy. The bench provokes each case directly:
- In transmit mode it pulses an advance while rewriting the read pointer.
- It then mixes long stretches of random strobes in both directions.

Every cycle, the bench compares both pointers, both sizes and both requests against a behavioural integer model. That comparison shows whether the right update won and whether the full and empty gating used the occupancy from before the edge.

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker #(
  parameter int OFS_W = 16,
  localparam int PW = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rx_i,
  input  logic             hw_adv_i,
  input  logic             sw_rd_we_i,
  input  logic             sw_wr_we_i,
  input  logic [PW-1:0]    sw_ptr_i,
  input  logic [OFS_W-1:0] len_i,
  input  logic [OFS_W-1:0] thr_i,
  output logic [PW-1:0]    rd_ptr_o,
  output logic [PW-1:0]    wr_ptr_o,
  output logic [OFS_W-1:0] valid_o,
  output logic [OFS_W-1:0] left_o,
  output logic             rx_req_o,
  output logic             tx_req_o
);

  logic [PW-1:0]    rd_q, wr_q;
  logic [OFS_W:0]   span;
  logic             wraps_differ, full, empty;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [OFS_W-1:0] len);
    logic [OFS_W-1:0] nxt;
    nxt = p[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};
    if (nxt == len) return {~p[OFS_W], {OFS_W{1'b0}}};
    return {p[OFS_W], nxt};
  endfunction

  assign wraps_differ = rd_q[OFS_W] ^ wr_q[OFS_W];
  assign span = {1'b0, wr_q[OFS_W-1:0]} - {1'b0, rd_q[OFS_W-1:0]}
              + (wraps_differ ? {1'b0, len_i} : {(OFS_W+1){1'b0}});

  assign valid_o  = span[OFS_W-1:0];
  assign left_o   = len_i - valid_o;
  assign full     = (valid_o == len_i);
  assign empty    = (valid_o == '0);
  assign rx_req_o = (valid_o >= thr_i);
  assign tx_req_o = (left_o >= thr_i);
  assign rd_ptr_o = rd_q;
  assign wr_ptr_o = wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || len_i == '0) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (sw_wr_we_i)                     wr_q <= sw_ptr_i;
      else if (dir_rx_i && hw_adv_i && !full) wr_q <= step(wr_q, len_i);
      if (sw_rd_we_i)                     rd_q <= sw_ptr_i;
      else if (!dir_rx_i && hw_adv_i && !empty) rd_q <= step(rd_q, len_i);
    end
  end

endmodule

// File: rtl/ring_ptr_tracker_chk.sv
module ring_ptr_tracker_chk #(
  parameter int OFS_W = 16,
  localparam int PW = OFS_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_rx_i,
  input logic             hw_adv_i,
  input logic             sw_rd_we_i,
  input logic             sw_wr_we_i,
  input logic [PW-1:0]    sw_ptr_i,
  input logic [OFS_W-1:0] len_i,
  input logic [PW-1:0]    rd_ptr_o,
  input logic [PW-1:0]    wr_ptr_o,
  input logic [OFS_W-1:0] valid_o,
  input logic [OFS_W-1:0] left_o
);

  a_r2_adv_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rx_i && hw_adv_i && !sw_wr_we_i && len_i != '0 && valid_o != len_i)
    |=> wr_ptr_o != $past(wr_ptr_o));

  a_r5_sizes_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o + left_o) == len_i);

  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rx_i && hw_adv_i && !sw_wr_we_i && len_i != '0 && valid_o == len_i)
    |=> $stable(wr_ptr_o));

  a_r7_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx_i && hw_adv_i && !sw_rd_we_i && len_i != '0 && valid_o == '0)
    |=> $stable(rd_ptr_o));

  a_r9_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_we_i && len_i != '0) |=> rd_ptr_o == $past(sw_ptr_i));

  a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (len_i == '0) |=> (rd_ptr_o == '0 && wr_ptr_o == '0));

endmodule

bind ring_ptr_tracker ring_ptr_tracker_chk #(.OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dir_rx_i(dir_rx_i), .hw_adv_i(hw_adv_i),
  .sw_rd_we_i(sw_rd_we_i), .sw_wr_we_i(sw_wr_we_i), .sw_ptr_i(sw_ptr_i),
  .len_i(len_i), .rd_ptr_o(rd_ptr_o), .wr_ptr_o(wr_ptr_o),
  .valid_o(valid_o), .left_o(left_o));

// File: tb/ring_ptr_tracker_tb_top.sv
`timescale 1ns/1ps
module ring_ptr_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rx = 1'b1, hw_adv = 1'b0, sw_rd_we = 1'b0, sw_wr_we = 1'b0;
  logic [16:0] sw_ptr = '0;
  logic [15:0] len = 16'd10, thr = 16'd8;
  logic [16:0] rd_ptr, wr_ptr;
  logic [15:0] valid, left;
  logic        rx_req, tx_req;

  int n_run = 0, n_fail = 0;
  int m_rd = 0, m_wr = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  ring_ptr_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .dir_rx_i(dir_rx), .hw_adv_i(hw_adv),
    .sw_rd_we_i(sw_rd_we), .sw_wr_we_i(sw_wr_we), .sw_ptr_i(sw_ptr),
    .len_i(len), .thr_i(thr), .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr),
    .valid_o(valid), .left_o(left), .rx_req_o(rx_req), .tx_req_o(tx_req));

  function automatic int m_valid();
    int d;
    d = (m_wr & 'hFFFF) - (m_rd & 'hFFFF);
    if (((m_wr >> 16) & 1) != ((m_rd >> 16) & 1)) d += int'(len);
    return d & 'hFFFF;
  endfunction

  function automatic int m_step(int p);
    int n;
    n = ((p & 'hFFFF) + 1) & 'hFFFF;
    if (n == int'(len)) return (p ^ 'h10000) & 'h10000;
    return (p & 'h10000) | n;
  endfunction

  always @(posedge clk) begin
    int v, nrd, nwr;
    if (!rst_n || len == 0) begin
      m_rd = 0; m_wr = 0;
    end else begin
      v = m_valid();
      nwr = m_wr; nrd = m_rd;
      if (sw_wr_we) nwr = int'(sw_ptr);
      else if (dir_rx && hw_adv && v != int'(len)) nwr = m_step(m_wr);
      if (sw_rd_we) nrd = int'(sw_ptr);
      else if (!dir_rx && hw_adv && v != 0) nrd = m_step(m_rd);
      m_wr = nwr; m_rd = nrd;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int v, l;
    #1;
    v = m_valid();
    l = (int'(len) - v) & 'hFFFF;
    n_run++;
    if (int'(rd_ptr) != m_rd || int'(wr_ptr) != m_wr || int'(valid) != v ||
        int'(left) != l || rx_req != (v >= int'(thr)) || tx_req != (l >= int'(thr))) begin
      n_fail++;
      $display("FAIL %s model: actual rd=%h wr=%h v=%0d l=%0d rx=%b tx=%b expected rd=%h wr=%h v=%0d l=%0d rx=%b tx=%b",
               tag, rd_ptr, wr_ptr, valid, left, rx_req, tx_req, m_rd, m_wr, v, l,
               v >= int'(thr), l >= int'(thr));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    tag = "R1";
    check(rd_ptr == 0 && wr_ptr == 0, "R1 pointers", int'(rd_ptr | wr_ptr), 0);
    check(valid == 0 && left == 10, "R1 left", int'(left), 10);

    tag = "R2 R3 R7 rx fill";
    dir_rx = 1'b1; hw_adv = 1'b1;
    cyc(12);
    hw_adv = 1'b0;
    cyc(1);
    check(wr_ptr == 17'h10000, "R3 wrap", int'(wr_ptr), 'h10000);
    check(valid == 10, "R7 full held", int'(valid), 10);
    check(rx_req == 1'b1, "R6 rx req", int'(rx_req), 1);

    tag = "R8 drain";
    sw_rd_we = 1'b1; sw_ptr = 17'h10000;
    cyc(1);
    sw_rd_we = 1'b0;
    cyc(1);
    check(valid == 0 && left == 10, "R8 drained", int'(valid), 0);

    tag = "R4 R6 rx partial";
    hw_adv = 1'b1;
    cyc(4);
    hw_adv = 1'b0;
    cyc(1);
    check(valid == 4 && rx_req == 1'b0, "R6 below thr", int'(valid), 4);

    tag = "R2 R7 tx drain";
    dir_rx = 1'b0; thr = 16'd3; hw_adv = 1'b1;
    cyc(6);
    hw_adv = 1'b0;
    cyc(1);
    check(rd_ptr == 17'h10004, "R7 empty held", int'(rd_ptr), 'h10004);
    check(tx_req == 1'b1, "R6 tx req", int'(tx_req), 1);

    tag = "R4 R8 sw write";
    sw_wr_we = 1'b1; sw_ptr = 17'h00003;
    cyc(1);
    sw_wr_we = 1'b0;
    cyc(1);
    check(valid == 9, "R4 wrap differ", int'(valid), 9);

    tag = "R9 same cycle";
    hw_adv = 1'b1; sw_rd_we = 1'b1; sw_ptr = 17'h10006;
    cyc(1);
    hw_adv = 1'b0; sw_rd_we = 1'b0;
    cyc(1);
    check(rd_ptr == 17'h10006, "R9 sw wins", int'(rd_ptr), 'h10006);
    check(valid == 7 && left == 3, "R5 sum", int'(left), 3);

    tag = "R9 split pointers";
    hw_adv = 1'b1; sw_wr_we = 1'b1; sw_ptr = 17'h00008;
    cyc(1);
    hw_adv = 1'b0; sw_wr_we = 1'b0;
    cyc(1);
    check(rd_ptr == 17'h10007 && wr_ptr == 17'h00008, "R9 both", int'(rd_ptr), 'h10007);

    tag = "R10 zero length";
    len = 16'd0; dir_rx = 1'b1; hw_adv = 1'b1;
    cyc(3);
    check(rd_ptr == 0 && wr_ptr == 0, "R10 held", int'(rd_ptr | wr_ptr), 0);
    hw_adv = 1'b0; len = 16'd12;
    cyc(1);

    tag = "R2 R3 R4 R5 R6 R7 R9 random";
    for (int i = 0; i < 4000; i++) begin
      dir_rx   = 1'($urandom_range(0, 1));
      hw_adv   = ($urandom_range(0, 9) < 7);
      sw_rd_we = ($urandom_range(0, 19) == 0);
      sw_wr_we = ($urandom_range(0, 19) == 0);
      sw_ptr   = {1'($urandom_range(0, 1)), 16'($urandom_range(0, 11))};
      thr      = 16'($urandom_range(0, 13));
      len      = ($urandom_range(0, 199) == 0) ? 16'd0 : 16'd12;
      cyc(1);
    end
    hw_adv = 1'b0; sw_rd_we = 1'b0; sw_wr_we = 1'b0;
    cyc(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule